// File: doc/BRIEF.md
# Gated Sixteen-Bit Timer with Comparator Synchronisation

This block is a 16-bit up-counter that runs from one fast system clock. The timer clock is not a real clock. It is a series of rising-edge and falling-edge events. The events come from either the full system clock or a quarter-rate instruction clock, and then pass through a prescaler that divides by 1, 2, 4 or 8. The counter advances only on a rising event. It does so only while the timer is enabled and the gate allows it.

The gate can come from two places, chosen in software. One is an external gate pin, brought in through a two-flop synchroniser. The other is a comparator output, modelled here as a digital input. The comparator path always has a two-flop synchroniser. It can optionally be latched on the falling event of the prescaled timer clock. Because the latch changes half a period away from the increment, a comparator change never races an increment.

A byte-wide control register holds the clock select, hysteresis enable, gate source and synchronisation enable bits. The hysteresis enable bit is passed out to the analog side. Software can load the counter through a strobe. The counter reports each wrap with a one-cycle pulse.

Top module: `gated_timer`

## Requirements
- R1: After reset the control register reads 0x02, the count is 0x0000, and the overflow pulse and hysteresis output are low.
- R2: Control register bit 5 is the clock select, bit 4 the hysteresis enable (driven on hyst_o), bit 1 the gate source and bit 0 the sync enable. Bits 7, 6, 3 and 2 ignore writes and read 0, so writing 0xFF reads back 0x33.
- R3: With clock select 1 the timer clock runs at the system clock rate. With clock select 0 it runs at one quarter of that rate.
- R4: presc_sel_i values 0, 1, 2 and 3 divide the selected clock by 1, 2, 4 and 8, giving a period of P system cycles. After enabling, the count rises once every P cycles, first at the P-th cycle. Disabling the timer clears the prescaler phase.
- R5: While timer_en_i is low the count holds.
- R6: While gate_en_i is low the count advances whatever the gate pin or comparator level.
- R7: With gate_en_i high and gate source 1, a low synchronised gate pin holds the count and a high one lets it advance.
- R8: With gate_en_i high and gate source 0, a low comparator level holds the count and a high one lets it advance.
- R9: With sync enable 0, cmp_o follows cmp_i two system clocks later.
- R10: With sync enable 1, cmp_o changes only at the falling event of the prescaled timer clock. This event falls at phase P/2-1 of each period. Rising events use the latched value as the gate.
- R11: The count wraps from 0xFFFF to 0x0000. On that same clock ovf_o pulses high for exactly one cycle.
- R12: load_i writes load_val_i into the count on the next clock. A load takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data |
| presc_sel_i | input | 2 | Prescaler ratio select |
| timer_en_i | input | 1 | Timer enable |
| gate_en_i | input | 1 | Gate enable |
| gate_pin_i | input | 1 | External gate pin, asynchronous, active high |
| cmp_i | input | 1 | Comparator output, asynchronous |
| load_i | input | 1 | Count load strobe |
| load_val_i | input | 16 | Value to load |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle wrap pulse |
| cmp_o | output | 1 | Comparator level as seen by the gate |
| hyst_o | output | 1 | Hysteresis enable to the comparator |

## Verification
The bench checks the first increment after enable for every prescaler ratio. A design that ran its phase counter freely, or did not clear it on disable, would count one tick early or late. The synchronised comparator test moves cmp_i mid-period and checks that cmp_o holds until the falling event and that the next rising event uses the new level. A design that latched on the rising event, or not at all, would count in the wrong period. Other cases are the wrap pulse, a load in the same cycle as an increment, and writes to the unused control bits. A design that got these wrong would pulse for longer than one cycle, lose the load, or read back stray bits.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int CTRL_W     = 8;
  localparam int BIT_CLKSEL = 5;
  localparam int BIT_HYST   = 4;
  localparam int BIT_GSRC   = 1;
  localparam int BIT_SYNC   = 0;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h02;

  typedef struct packed {
    logic clk_full;
    logic hyst;
    logic gate_pin_sel;
    logic sync_en;
  } ctrl_t;
endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gtmr_ctrl_reg.sv
module gtmr_ctrl_reg
  import gtmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.clk_full     <= CTRL_RST[BIT_CLKSEL];
      ctrl_q.hyst         <= CTRL_RST[BIT_HYST];
      ctrl_q.gate_pin_sel <= CTRL_RST[BIT_GSRC];
      ctrl_q.sync_en      <= CTRL_RST[BIT_SYNC];
    end else if (we_i) begin
      ctrl_q.clk_full     <= wdata_i[BIT_CLKSEL];
      ctrl_q.hyst         <= wdata_i[BIT_HYST];
      ctrl_q.gate_pin_sel <= wdata_i[BIT_GSRC];
      ctrl_q.sync_en      <= wdata_i[BIT_SYNC];
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[BIT_CLKSEL] = ctrl_q.clk_full;
    rdata_o[BIT_HYST]   = ctrl_q.hyst;
    rdata_o[BIT_GSRC]   = ctrl_q.gate_pin_sel;
    rdata_o[BIT_SYNC]   = ctrl_q.sync_en;
  end

  // unimplemented write bits
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[7:6], wdata_i[3:2]};

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/gtmr_edge_gen.sv
// Phase counter spanning instruction divide and prescale; emits rise/fall events.
module gtmr_edge_gen #(
  parameter int INSTR_LOG2 = 2,
  parameter int PRE_W      = 2,
  localparam int PH_W      = INSTR_LOG2 + (1 << PRE_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clk_full_i,
  input  logic [PRE_W-1:0] div_sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PH_W:0]   base, period;
  logic [PH_W-1:0] last, half, ph_q;
  logic            single;

  always_comb begin
    base   = clk_full_i ? (PH_W+1)'(1) : ((PH_W+1)'(1) << INSTR_LOG2);
    period = base << div_sel_i;
    last   = PH_W'(period - (PH_W+1)'(1));
    half   = PH_W'((period >> 1) - (PH_W+1)'(1));
    single = (period == (PH_W+1)'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_q <= '0;
    else if (!en_i)        ph_q <= '0;
    else if (ph_q >= last) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end

  assign rise_o = en_i && (ph_q == last);
  assign fall_o = en_i && (single || (ph_q == half));
endmodule

// File: rtl/gtmr_cmp_path.sv
module gtmr_cmp_path #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_raw_i,
  input  logic fall_i,
  input  logic sync_en_i,
  output logic cmp_o
);
  logic cmp_s, cmp_lat_q;

  gtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_s)
  );

  // capture half a period away from the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_lat_q <= 1'b0;
    else if (fall_i) cmp_lat_q <= cmp_s;
  end

  assign cmp_o = sync_en_i ? cmp_lat_q : cmp_s;
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (inc_i) begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= &cnt_q;
      end
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 2,
  parameter int INSTR_LOG2  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic [PRE_W-1:0]  presc_sel_i,
  input  logic              timer_en_i,
  input  logic              gate_en_i,
  input  logic              gate_pin_i,
  input  logic              cmp_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic              cmp_o,
  output logic              hyst_o
);
  ctrl_t ctrl;
  logic  rise_evt, fall_evt, gate_s, cmp_gate, gate_ok, inc;

  gtmr_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we_i),
    .wdata_i(ctrl_wdata_i),
    .rdata_o(ctrl_rdata_o),
    .ctrl_o (ctrl)
  );

  gtmr_edge_gen #(.INSTR_LOG2(INSTR_LOG2), .PRE_W(PRE_W)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (timer_en_i),
    .clk_full_i(ctrl.clk_full),
    .div_sel_i (presc_sel_i),
    .rise_o    (rise_evt),
    .fall_o    (fall_evt)
  );

  gtmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_pin_i),
    .q_o   (gate_s)
  );

  gtmr_cmp_path #(.SYNC_STAGES(SYNC_STAGES)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_raw_i(cmp_i),
    .fall_i   (fall_evt),
    .sync_en_i(ctrl.sync_en),
    .cmp_o    (cmp_gate)
  );

  assign gate_ok = !gate_en_i || (ctrl.gate_pin_sel ? gate_s : cmp_gate);
  assign inc     = rise_evt && timer_en_i && gate_ok;

  gtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .inc_i     (inc),
    .count_o   (count_o),
    .ovf_o     (ovf_o)
  );

  assign cmp_o  = cmp_gate;
  assign hyst_o = ctrl.hyst;
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             timer_en_i,
  input logic             ctrl_we_i,
  input logic [7:0]       ctrl_rdata_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             cmp_o,
  input logic             gate_ok,
  input logic             fall_evt
);
  // R11
  ovf_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  // R11
  ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == '0);

  // R12
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R5
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_en_i && !load_i) |=> $stable(count_o));

  // R7
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_ok && !load_i) |=> $stable(count_o));

  // R10
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[0] && !fall_evt && !ctrl_we_i) |=> $stable(cmp_o));

  // R2
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_rdata_o[7:6] == 2'b00 && ctrl_rdata_o[3:2] == 2'b00));
endmodule

bind gated_timer gtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .timer_en_i  (timer_en_i),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .count_o     (count_o),
  .ovf_o       (ovf_o),
  .cmp_o       (cmp_o),
  .gate_ok     (gate_ok),
  .fall_evt    (fall_evt)
);

// File: tb/gated_timer_test.sv
`timescale 1ns/1ps
module gated_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata;
  logic [1:0]  presc = '0;
  logic        timer_en = 1'b0, gate_en = 1'b0, gate_pin = 1'b1, cmp = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [15:0] count;
  logic        ovf, cmp_out, hyst;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; int exp; string req; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  gated_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .presc_sel_i(presc), .timer_en_i(timer_en),
    .gate_en_i(gate_en), .gate_pin_i(gate_pin), .cmp_i(cmp), .load_i(load),
    .load_val_i(load_val), .count_o(count), .ovf_o(ovf), .cmp_o(cmp_out), .hyst_o(hyst)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t it;
      int act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = int'(count);
        1: act = int'(ctrl_rdata);
        2: act = int'(ovf);
        3: act = int'(cmp_out);
        default: act = int'(hyst);
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s: kind %0d actual 0x%0h expected 0x%0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_v(input int kind, input int exp, input string req);
    exp_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; tick(1); ctrl_we = 1'b0;
  endtask

  task automatic load_cnt(input logic [15:0] v);
    load = 1'b1; load_val = v; tick(1); load = 1'b0;
  endtask

  task automatic run(input int n);
    timer_en = 1'b1; tick(n); timer_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    expect_v(0, 0, "R1"); expect_v(1, 8'h02, "R1");
    expect_v(2, 0, "R1"); expect_v(4, 0, "R1");
    tick(1);
    // R2
    wr_ctrl(8'hFF);
    expect_v(1, 8'h33, "R2"); expect_v(4, 1, "R2");
    wr_ctrl(8'h20);
    expect_v(1, 8'h20, "R2"); expect_v(4, 0, "R2");
    // R3 full clock, divide 1
    presc = 2'd0; load_cnt(16'h0); run(10); expect_v(0, 10, "R3");
    // R4 divide 4 and 2 on full clock
    presc = 2'd2; load_cnt(16'h0); run(21); expect_v(0, 5, "R4");
    presc = 2'd1; load_cnt(16'h0); run(9);  expect_v(0, 4, "R4");
    // R3 instruction clock
    wr_ctrl(8'h00);
    presc = 2'd0; load_cnt(16'h0); run(20); expect_v(0, 5, "R3");
    // R4 divide 8 on instruction clock, period 32
    presc = 2'd3; load_cnt(16'h0); run(70); expect_v(0, 2, "R4");
    // R4 phase cleared on disable
    presc = 2'd0; load_cnt(16'h0); run(3); expect_v(0, 0, "R4");
    tick(2); run(3); expect_v(0, 0, "R4");
    // R5 disabled holds
    wr_ctrl(8'h20); load_cnt(16'h0055); tick(10); expect_v(0, 16'h0055, "R5");
    // R6 gate disabled ignores low pin
    wr_ctrl(8'h22); gate_pin = 1'b0; gate_en = 1'b0; tick(4);
    load_cnt(16'h0); run(8); expect_v(0, 8, "R6");
    // R7 pin gate
    gate_en = 1'b1; load_cnt(16'h0); run(8); expect_v(0, 0, "R7");
    gate_pin = 1'b1; tick(4); run(8); expect_v(0, 8, "R7");
    // R8 comparator gate, no sync
    wr_ctrl(8'h20); cmp = 1'b0; tick(4);
    load_cnt(16'h0); run(8); expect_v(0, 0, "R8");
    cmp = 1'b1; tick(4); run(8); expect_v(0, 8, "R8");
    // R9 two-clock follow
    cmp = 1'b0; tick(1); expect_v(3, 1, "R9");
    tick(1); expect_v(3, 0, "R9");
    // R10 latched on fall event, period 32, fall at phase 15
    wr_ctrl(8'h01); presc = 2'd3; tick(4);
    load_cnt(16'h0);
    timer_en = 1'b1;
    tick(20); expect_v(3, 0, "R10");
    tick(20);
    cmp = 1'b1;
    tick(4);  expect_v(3, 0, "R10");
    tick(6);  expect_v(3, 1, "R10");
    tick(20); timer_en = 1'b0; expect_v(0, 1, "R10");
    // R11 wrap
    wr_ctrl(8'h20); gate_en = 1'b0; presc = 2'd0;
    load_cnt(16'hFFFE);
    run(1); expect_v(0, 16'hFFFF, "R11"); expect_v(2, 0, "R11");
    run(1); expect_v(0, 0, "R11"); expect_v(2, 1, "R11");
    tick(1); expect_v(2, 0, "R11");
    // R12 load wins over increment
    load = 1'b1; load_val = 16'h4000; timer_en = 1'b1;
    tick(1); load = 1'b0; expect_v(0, 16'h4000, "R12");
    tick(3); timer_en = 1'b0; expect_v(0, 16'h4003, "R12");
    tick(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule